// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning and Sticky Overflow Cause

This block guards a microcontroller subsystem against a hung program. A free-running counter advances on every clock. Firmware must restart it before it reaches its timeout. If it reaches the timeout, the block emits a one-cycle system-reset pulse and the counter starts again from zero. A fixed number of cycles before that point, the block raises a warning flag. Firmware or a wake event can then react before the reset arrives.

An overflow also sets a sticky cause bit. The reset pulse this block generates does not clear that bit, so boot code can read why the system restarted. Three things clear the bit: a firmware write of 0, the external reset input held high, and entry into the deepest sleep state.

Firmware controls the block with whole-byte writes to a command byte. Bit 7 set means "restart". Bit 7 clear means "clear the warning". The warning flag and the cause bit each also have a one-bit write port.

Top module: `wdt_sentinel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `warn_o`, `ovf_o` and `sys_rst_o` are all 0. The counter is at zero.
- R2: With no restart, `sys_rst_o` is high for exactly one cycle, TIMEOUT_CYC clock edges after the last restart edge (or the last reset edge). It then repeats every TIMEOUT_CYC edges.
- R3: `warn_o` rises exactly LEAD_CYC cycles before the `sys_rst_o` pulse. It stays high until it is cleared.
- R4: A command-byte write with bit 7 = 1 restarts the counter from zero, whatever the other seven bits are. The next pulse then arrives TIMEOUT_CYC edges later. The write does not clear `warn_o`.
- R5: A command-byte write with bit 7 = 0 clears `warn_o`. It does not restart the counter.
- R6: A warning-flag write with data 0 clears `warn_o`. A write with data 1 has no effect.
- R7: A falling edge on `wake_i` clears `warn_o`. A rising edge has no effect.
- R8: The overflow that produces the `sys_rst_o` pulse also sets `ovf_o`, and `ovf_o` stays set afterwards. A cause-bit write with data 0 clears it. A write with data 1 has no effect.
- R9: While `ext_rst_i` is high, `ovf_o` is held at 0, the counter is held at zero and no pulse occurs. After release, the pulse arrives TIMEOUT_CYC edges after the last edge at which `ext_rst_i` was high.
- R10: A cycle with `deep_sleep_i` high clears `ovf_o`. This includes a cycle that coincides with an overflow.
- R11: A restart write in the cycle in which the counter would overflow takes priority. No pulse occurs, `ovf_o` is not set, and the counter restarts.
- R12: If the warning point and a warning clear (command write or flag write) occur in the same cycle, `warn_o` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; clears all state |
| ctl_we_i | input | 1 | Command-byte write strobe |
| ctl_data_i | input | 8 | Command byte; bit 7 selects restart (1) or warning clear (0) |
| warn_we_i | input | 1 | Warning-flag write strobe |
| warn_wdata_i | input | 1 | Warning-flag write data; 0 clears |
| ovf_we_i | input | 1 | Cause-bit write strobe |
| ovf_wdata_i | input | 1 | Cause-bit write data; 0 clears |
| wake_i | input | 1 | Wake signal; its falling edge clears the warning |
| ext_rst_i | input | 1 | External reset; holds the counter and clears the cause bit while high |
| deep_sleep_i | input | 1 | Deepest-sleep entry; clears the cause bit |
| warn_o | output | 1 | Early-warning flag |
| ovf_o | output | 1 | Sticky overflow cause bit |
| sys_rst_o | output | 1 | One-cycle system-reset pulse on overflow |

## Verification
The hardest situations to reach are the collisions on a single clock edge:
- a restart write landing in the exact terminal cycle of the count;
- a warning clear landing in the exact cycle the warning point is crossed.

The bench uses a 16-cycle timeout with a 4-cycle lead. It sweeps the restart write across every offset from 1 to the full timeout. For each offset it predicts the next pulse, the warning level and the cause bit arithmetically from that offset. Separate runs count precisely to the warning edge and the terminal edge before issuing clears, wake edges, external reset or sleep. This exposes each priority decision at the port level.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned CTL_BYTE_W = 8;
  localparam int unsigned CTL_GO_BIT = 7;

  typedef struct packed {
    logic restart;
    logic warn_clr;
  } ctl_cmd_t;

  // Whole-byte command: bit CTL_GO_BIT high restarts, low clears the warning.
  function automatic ctl_cmd_t decode_ctl(input logic we,
                                          input logic [CTL_BYTE_W-1:0] data);
    ctl_cmd_t c;
    c.restart  = we &  data[CTL_GO_BIT];
    c.warn_clr = we & ~data[CTL_GO_BIT];
    return c;
  endfunction

endpackage

// File: rtl/wdt_fall_detect.sv
module wdt_fall_detect (
  input  logic clk,
  input  logic sig_i,
  output logic fall_o
);

  // Unreset history register so the detector sees the same edges at all times.
  logic sig_q;

  always_ff @(posedge clk) begin
    sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int unsigned TIMEOUT_CYC = 1500000,
  parameter int unsigned LEAD_CYC    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic restart_i,
  output logic warn_hit_o,
  output logic expire_o
);

  localparam int unsigned CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(TIMEOUT_CYC - 1 - LEAD_CYC);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             advance;

  assign advance = ~hold_i & ~restart_i;

  always_comb begin
    expire_o   = advance && (cnt_q == LAST_V);
    warn_hit_o = advance && (cnt_q == WARN_V);
  end

  always_ff @(posedge clk) begin
    if (rst || !advance) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST_V) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE_V;
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0)); // R4

  AST_EXPIRE_WRAPS: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> ((cnt_q == '0) && !expire_o)); // R2

  AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/wdt_status_flags.sv
module wdt_status_flags (
  input  logic clk,
  input  logic rst,
  input  logic warn_set_i,
  input  logic warn_clr_i,
  input  logic ovf_set_i,
  input  logic ovf_wr_clr_i,
  input  logic ovf_hard_clr_i,
  output logic warn_o,
  output logic ovf_o
);

  logic warn_q;
  logic ovf_q;

  // Warning: a new crossing beats any clear arriving with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q <= 1'b0;
    end else if (warn_set_i) begin
      warn_q <= 1'b1;
    end else if (warn_clr_i) begin
      warn_q <= 1'b0;
    end
  end

  // Cause bit: external reset and sleep dominate; a new overflow beats a write.
  always_ff @(posedge clk) begin
    if (rst || ovf_hard_clr_i) begin
      ovf_q <= 1'b0;
    end else if (ovf_set_i) begin
      ovf_q <= 1'b1;
    end else if (ovf_wr_clr_i) begin
      ovf_q <= 1'b0;
    end
  end

  assign warn_o = warn_q;
  assign ovf_o  = ovf_q;

  AST_WARN_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    warn_set_i |=> warn_q); // R12

  AST_WARN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (warn_clr_i && !warn_set_i) |=> !warn_q); // R5

  AST_OVF_HARD_CLR: assert property (@(posedge clk) disable iff (rst)
    ovf_hard_clr_i |=> !ovf_q); // R9

endmodule

// File: rtl/wdt_sentinel.sv
module wdt_sentinel #(
  parameter int unsigned TIMEOUT_CYC = 1500000,
  parameter int unsigned LEAD_CYC    = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_data_i,
  input  logic       warn_we_i,
  input  logic       warn_wdata_i,
  input  logic       ovf_we_i,
  input  logic       ovf_wdata_i,
  input  logic       wake_i,
  input  logic       ext_rst_i,
  input  logic       deep_sleep_i,
  output logic       warn_o,
  output logic       ovf_o,
  output logic       sys_rst_o
);

  import wdt_pkg::*;

  ctl_cmd_t cmd;
  logic     wake_fall;
  logic     warn_hit;
  logic     expire;
  logic     warn_clr;
  logic     ovf_wr_clr;
  logic     ovf_hard_clr;
  logic     sys_rst_q;

  assign cmd          = decode_ctl(ctl_we_i, ctl_data_i);
  assign warn_clr     = cmd.warn_clr | (warn_we_i & ~warn_wdata_i) | wake_fall;
  assign ovf_wr_clr   = ovf_we_i & ~ovf_wdata_i;
  assign ovf_hard_clr = ext_rst_i | deep_sleep_i;

  wdt_fall_detect u_wake_edge (
    .clk    (clk),
    .sig_i  (wake_i),
    .fall_o (wake_fall)
  );

  wdt_tick_counter #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .LEAD_CYC    (LEAD_CYC)
  ) u_counter (
    .clk        (clk),
    .rst        (rst),
    .hold_i     (ext_rst_i),
    .restart_i  (cmd.restart),
    .warn_hit_o (warn_hit),
    .expire_o   (expire)
  );

  wdt_status_flags u_flags (
    .clk            (clk),
    .rst            (rst),
    .warn_set_i     (warn_hit),
    .warn_clr_i     (warn_clr),
    .ovf_set_i      (expire),
    .ovf_wr_clr_i   (ovf_wr_clr),
    .ovf_hard_clr_i (ovf_hard_clr),
    .warn_o         (warn_o),
    .ovf_o          (ovf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_q <= 1'b0;
    end else begin
      sys_rst_q <= expire;
    end
  end

  assign sys_rst_o = sys_rst_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o); // R2

  AST_PULSE_MARKS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_o && !$past(deep_sleep_i)) |-> ovf_o); // R8

  AST_EXT_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    ext_rst_i |=> (!ovf_o && !sys_rst_o)); // R9

  AST_SLEEP_DROPS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    deep_sleep_i |=> !ovf_o); // R10

  AST_WAKE_FALL_CLR: assert property (@(posedge clk) disable iff (rst)
    ($fell(wake_i) && !warn_hit) |=> !warn_o); // R7

  AST_RESTART_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (ctl_we_i && ctl_data_i[7]) |=> !sys_rst_o); // R11

endmodule

// File: tb/test_wdt_sentinel.sv
module test_wdt_sentinel;

  localparam int CLK_PERIOD = 10;
  localparam int T = 16;
  localparam int L = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic       warn_we = 1'b0;
  logic       warn_wdata = 1'b0;
  logic       ovf_we = 1'b0;
  logic       ovf_wdata = 1'b0;
  logic       wake = 1'b0;
  logic       ext_rst = 1'b0;
  logic       deep_sleep = 1'b0;
  logic       warn_o;
  logic       ovf_o;
  logic       sys_rst_o;

  int n_cmp = 0;
  int n_mis = 0;
  bit done  = 1'b0;

  wdt_sentinel #(.TIMEOUT_CYC(T), .LEAD_CYC(L)) i_wdt_sentinel (
    .clk          (clk),
    .rst          (rst),
    .ctl_we_i     (ctl_we),
    .ctl_data_i   (ctl_data),
    .warn_we_i    (warn_we),
    .warn_wdata_i (warn_wdata),
    .ovf_we_i     (ovf_we),
    .ovf_wdata_i  (ovf_wdata),
    .wake_i       (wake),
    .ext_rst_i    (ext_rst),
    .deep_sleep_i (deep_sleep),
    .warn_o       (warn_o),
    .ovf_o        (ovf_o),
    .sys_rst_o    (sys_rst_o)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_mis++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic quiet();
    ctl_we = 1'b0; warn_we = 1'b0; ovf_we = 1'b0;
  endtask

  // Restart and clear both flags in one edge; afterwards the offset is zero.
  task automatic restart_clean();
    ctl_we = 1'b1; ctl_data = 8'h80;
    warn_we = 1'b1; warn_wdata = 1'b0;
    ovf_we = 1'b1; ovf_wdata = 1'b0;
    step();
    quiet();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_mis++;
    $display("FAIL R2 watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    #1;
    repeat (3) step();
    // R1: outputs idle under reset
    chk("R1 warn", warn_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 sys_rst", sys_rst_o, 0);
    rst = 1'b0;

    // R2 R3 R8: free run from reset release over two periods
    for (int n = 1; n <= 2*T + 1; n++) begin
      step();
      chk("R2 pulse", sys_rst_o, int'(n == T || n == 2*T));
      chk("R3 warn", warn_o, int'(n >= T - L));
      chk("R8 ovf", ovf_o, int'(n >= T));
    end

    // R4 R11: restart at every offset, other command bits varied
    for (int r = 1; r <= T; r++) begin
      restart_clean();
      for (int k = 1; k < r; k++) step();
      ctl_we = 1'b1; ctl_data = 8'h80 | 8'(r);
      step();
      quiet();
      chk("R11 no pulse at restart", sys_rst_o, 0);
      chk("R11 ovf untouched", ovf_o, 0);
      for (int m = 1; m <= T; m++) begin
        step();
        chk("R4 pulse after restart", sys_rst_o, int'(m == T));
        chk("R4 warn kept", warn_o, int'((r - 1 >= T - L) || (m >= T - L)));
      end
    end

    // R5: bit 7 clear clears warning, no restart
    restart_clean();
    for (int k = 1; k <= T - L; k++) step();
    chk("R5 warn set", warn_o, 1);
    ctl_we = 1'b1; ctl_data = 8'h35;
    step();
    quiet();
    chk("R5 warn cleared", warn_o, 0);
    for (int n = T - L + 2; n <= T; n++) begin
      step();
      chk("R5 no restart", sys_rst_o, int'(n == T));
    end

    // R6: flag write 1 ignored, 0 clears
    restart_clean();
    warn_we = 1'b1; warn_wdata = 1'b1;
    step();
    quiet();
    chk("R6 write1 ignored", warn_o, 0);
    for (int k = 2; k <= T - L; k++) step();
    chk("R6 warn set", warn_o, 1);
    warn_we = 1'b1; warn_wdata = 1'b1;
    step();
    chk("R6 write1 keeps", warn_o, 1);
    warn_wdata = 1'b0;
    step();
    quiet();
    chk("R6 write0 clears", warn_o, 0);

    // R7: wake edges
    restart_clean();
    for (int k = 1; k <= T - L; k++) step();
    wake = 1'b1;
    step();
    chk("R7 rise ignored", warn_o, 1);
    wake = 1'b0;
    step();
    chk("R7 fall clears", warn_o, 0);

    // R12: clear coinciding with the warning point
    restart_clean();
    for (int k = 1; k < T - L; k++) step();
    warn_we = 1'b1; warn_wdata = 1'b0;
    step();
    quiet();
    chk("R12 set beats flag write", warn_o, 1);
    restart_clean();
    for (int k = 1; k < T - L; k++) step();
    ctl_we = 1'b1; ctl_data = 8'h00;
    step();
    quiet();
    chk("R12 set beats command clear", warn_o, 1);

    // R8: cause-bit writes
    restart_clean();
    for (int k = 1; k <= T; k++) step();
    chk("R8 ovf set", ovf_o, 1);
    ovf_we = 1'b1; ovf_wdata = 1'b1;
    step();
    chk("R8 write1 keeps", ovf_o, 1);
    ovf_wdata = 1'b0;
    step();
    chk("R8 write0 clears", ovf_o, 0);
    ovf_wdata = 1'b1;
    step();
    quiet();
    chk("R8 write1 no set", ovf_o, 0);

    // R9: external reset holds everything quiet
    restart_clean();
    for (int k = 1; k <= T; k++) step();
    chk("R9 ovf before", ovf_o, 1);
    ext_rst = 1'b1;
    for (int k = 1; k <= 2*T + 2; k++) begin
      step();
      chk("R9 ovf held", ovf_o, 0);
      chk("R9 no pulse", sys_rst_o, 0);
    end
    ext_rst = 1'b0;
    for (int m = 1; m <= T; m++) begin
      step();
      chk("R9 pulse after release", sys_rst_o, int'(m == T));
    end

    // R10: sleep clears cause bit, also on the overflow edge
    restart_clean();
    for (int k = 1; k <= T; k++) step();
    chk("R10 ovf before", ovf_o, 1);
    deep_sleep = 1'b1;
    step();
    deep_sleep = 1'b0;
    chk("R10 sleep clears", ovf_o, 0);
    restart_clean();
    for (int k = 1; k < T; k++) step();
    deep_sleep = 1'b1;
    step();
    deep_sleep = 1'b0;
    chk("R10 pulse still", sys_rst_o, 1);
    chk("R10 ovf dropped", ovf_o, 0);

    finish_run();
  end

endmodule